// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a watchdog counter steered by four one-cycle control strobes: start, stop, restart (kick) and interrupt acknowledge. Once started, it counts clock cycles. If software lets a full timeout interval pass without a kick, the block raises a level interrupt and moves to a warning state. This gives software one more interval to recover.

If a second interval then passes without a kick, the block enters a tripped state and drives its watchdog reset output high. The tripped state is sticky. Kicks and start or stop requests do not release it. Only the synchronous active-low bus reset returns the block to idle. A two-bit status output always shows the current expiry stage, so software can tell after a restart whether the watchdog caused it. The timeout length is a parameter counted in clock cycles.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to idle. After that edge, `state_o` is 0, `irq` is 0 and `wdt_rst` is 0.
- R2: In idle (`state_o` = 0) the counter stays at zero. No expiry occurs however long the block waits, and a kick or an acknowledge does not change the state.
- R3: `en_req` sampled in idle moves the block to counting (`state_o` = 1) at that edge with the counter at zero. The first expiry takes effect exactly `TIMEOUT_CYCLES` edges later.
- R4: On the first expiry, the block moves to warning (`state_o` = 2) and sets `irq` to 1. `wdt_rst` stays at 0.
- R5: If `TIMEOUT_CYCLES` edges pass in warning with no kick or stop, the block moves to tripped (`state_o` = 3). `wdt_rst` is 1 exactly while the state is tripped.
- R6: `irq` is a level. A sampled `irq_ack` or `kick` clears it in any state. If an expiry and an acknowledge fall in the same cycle, the expiry wins and `irq` is set. A stop request leaves `irq` unchanged.
- R7: In tripped, `kick`, `dis_req` and `en_req` have no effect: `state_o` stays 3 and `wdt_rst` stays 1.
- R8: The bus reset is the only way out of tripped. After a low `rst_n` edge, `state_o`, `irq` and `wdt_rst` are all 0.
- R9: A kick in counting or warning returns the block to counting with the counter cleared. The next expiry follows exactly `TIMEOUT_CYCLES` edges after the kick edge.
- R10: `dis_req` in counting or warning returns the block to idle and zeroes the counter. It overrides a kick in the same cycle. A later `en_req` starts a fresh full interval.
- R11: `en_req` sampled in counting or warning changes neither the state nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| en_req | input | 1 | Start strobe |
| dis_req | input | 1 | Stop strobe |
| kick | input | 1 | Restart strobe |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | First-expiry interrupt, level |
| wdt_rst | output | 1 | Watchdog reset, held while tripped |
| state_o | output | 2 | Expiry stage: 0 idle, 1 counting, 2 warning, 3 tripped |

## Verification
The state register drives `state_o` directly, so a wrong next-state decision appears at the ports on the edge right after the stimulus. A counter fault shows up differently. A counter that is not cleared, or that wraps at the wrong value, leaves the state correct until the expected expiry edge. It then shows as `irq` or `wdt_rst` changing one or more cycles early or late. The bench therefore samples one cycle before and exactly at each predicted expiry edge. A stage latch that fails to hold shows as `wdt_rst` dropping within a cycle of a kick or stop while the block is tripped.

// File: rtl/wdog_pkg.sv
// Package: shared state encoding for the two-stage watchdog.
// Assumes: the code values are visible to software through state_o and
// must not be renumbered.
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_WARN = 2'd2,
        WD_TRIP = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_interval.sv
// Module: interval counter. Counts cycles while run is high and emits a
// one-cycle expire pulse on the last cycle of each interval, then wraps.
// Assumes: TIMEOUT_CYCLES >= 2; restart has priority and suppresses expiry.
module wdog_interval #(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);

    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    // Detect the final cycle of an interval.
    assign at_last = (cnt_q == LAST);
    assign expire  = run && !restart && at_last;

    // Cycle counter: held at zero when stopped or restarted, wraps at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
// Module: expiry stage controller. Walks idle -> counting -> warning ->
// tripped and keeps a separate sticky trip flag for the reset output.
// Assumes: expire is already masked by kick/disable; only rst_n leaves TRIP.
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_req,
    input  logic      dis_req,
    input  logic      kick,
    input  logic      expire,
    output wd_state_e state_q,
    output logic      run,
    output logic      first_exp,
    output logic      trip_q
);

    wd_state_e state_n;

    // Next-state decision; stop beats kick, kick beats expiry.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WD_IDLE: if (en_req) state_n = WD_RUN;
            WD_RUN: begin
                if (dis_req)     state_n = WD_IDLE;
                else if (kick)   state_n = WD_RUN;
                else if (expire) state_n = WD_WARN;
            end
            WD_WARN: begin
                if (dis_req)     state_n = WD_IDLE;
                else if (kick)   state_n = WD_RUN;
                else if (expire) state_n = WD_TRIP;
            end
            WD_TRIP: state_n = WD_TRIP;
            default: state_n = WD_IDLE;
        endcase
    end

    // Counter runs only in the counting and warning stages.
    assign run       = (state_q == WD_RUN) || (state_q == WD_WARN);
    assign first_exp = expire && (state_q == WD_RUN);

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_n;
    end

    // Sticky reset flag, set on the second expiry, cleared only by bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               trip_q <= 1'b0;
        else if (expire && (state_q == WD_WARN))  trip_q <= 1'b1;
    end

endmodule

// File: rtl/wdog_irq.sv
// Module: level interrupt latch. Set on the first expiry, cleared by an
// acknowledge or a kick; a set in the same cycle wins over a clear.
// Assumes: set is a single-cycle pulse.
module wdog_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    input  logic kick,
    output logic irq
);

    // Interrupt flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (set)        irq <= 1'b1;
        else if (ack || kick) irq <= 1'b0;
    end

endmodule

// File: rtl/wdog_timer.sv
// Module: two-stage expiry watchdog top. Ties the interval counter, the
// stage controller and the interrupt latch together.
// Assumes: all control inputs are synchronous single-cycle strobes.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       dis_req,
    input  logic       kick,
    input  logic       irq_ack,
    output logic       irq,
    output logic       wdt_rst,
    output logic [1:0] state_o
);

    wd_state_e state_q;
    logic      run;
    logic      expire;
    logic      first_exp;
    logic      restart;

    // Any kick or stop clears the running interval.
    assign restart = kick || dis_req;

    wdog_interval #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(restart),
        .expire (expire)
    );

    wdog_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (en_req),
        .dis_req  (dis_req),
        .kick     (kick),
        .expire   (expire),
        .state_q  (state_q),
        .run      (run),
        .first_exp(first_exp),
        .trip_q   (wdt_rst)
    );

    wdog_irq u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (first_exp),
        .ack  (irq_ack),
        .kick (kick),
        .irq  (irq)
    );

    assign state_o = state_q;

endmodule

// File: rtl/wdog_timer_chk.sv
// Module: port-level property checker for wdog_timer, attached by bind.
module wdog_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_req,
    input logic       dis_req,
    input logic       kick,
    input logic       irq,
    input logic       wdt_rst,
    input logic [1:0] state_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_o == 2'd0) && !irq && !wdt_rst);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) && !en_req |=> (state_o == 2'd0));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) && en_req |=> (state_o == 2'd1));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (state_o == 2'd2) && !wdt_rst);

    // R5
    trip_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst == (state_o == 2'd3));

    // R7
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |=> (state_o == 2'd3) && wdt_rst);

    // R9
    kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 2'd1) || (state_o == 2'd2)) && kick && !dis_req
        |=> (state_o == 2'd1) && !irq);

    // R10
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 2'd1) || (state_o == 2'd2)) && dis_req |=> (state_o == 2'd0));

endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_req (en_req),
    .dis_req(dis_req),
    .kick   (kick),
    .irq    (irq),
    .wdt_rst(wdt_rst),
    .state_o(state_o)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0;
    logic       dis_req = 1'b0;
    logic       kick = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       wdt_rst;
    logic [1:0] state_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdog_timer #(.TIMEOUT_CYCLES(T)) u_wdog_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_req (en_req),
        .dis_req(dis_req),
        .kick   (kick),
        .irq_ack(irq_ack),
        .irq    (irq),
        .wdt_rst(wdt_rst),
        .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int st, input int iq, input int rs);
        chk({req, " state"}, int'(state_o), st);
        chk({req, " irq"}, int'(irq), iq);
        chk({req, " wdt_rst"}, int'(wdt_rst), rs);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle strobe of any combination of control inputs.
    task automatic strobe(input logic e, input logic d, input logic k, input logic a);
        en_req = e; dis_req = d; kick = k; irq_ack = a;
        @(negedge clk);
        en_req = 0; dis_req = 0; kick = 0; irq_ack = 0;
    endtask

    task automatic bus_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        bus_reset();
        expect_out("R1 reset", 0, 0, 0);
    endtask

    task automatic t_idle();
        bus_reset();
        wait_n(3 * T);
        expect_out("R2 idle wait", 0, 0, 0);
        strobe(0, 0, 1, 1);
        wait_n(T);
        expect_out("R2 idle kick", 0, 0, 0);
    endtask

    // First expiry, acknowledge, second expiry, sticky trip, release.
    task automatic t_two_stage();
        bus_reset();
        strobe(1, 0, 0, 0);
        chk("R3 started", int'(state_o), 1);
        wait_n(T - 1);
        expect_out("R3 before first expiry", 1, 0, 0);
        wait_n(1);
        expect_out("R4 first expiry", 2, 1, 0);
        strobe(0, 0, 0, 1);
        expect_out("R6 ack clears irq", 2, 0, 0);
        wait_n(T - 2);
        expect_out("R5 before second expiry", 2, 0, 0);
        wait_n(1);
        expect_out("R5 second expiry", 3, 0, 1);
        strobe(1, 1, 1, 0);
        wait_n(2 * T);
        expect_out("R7 trip holds", 3, 0, 1);
        strobe(0, 0, 1, 0);
        expect_out("R7 kick in trip", 3, 0, 1);
        bus_reset();
        expect_out("R8 release", 0, 0, 0);
    endtask

    task automatic t_kick();
        bus_reset();
        strobe(1, 0, 0, 0);
        wait_n(T - 2);
        strobe(0, 0, 1, 0);
        wait_n(T - 1);
        expect_out("R9 kick delays expiry", 1, 0, 0);
        wait_n(1);
        expect_out("R9 expiry after kick", 2, 1, 0);
        strobe(0, 0, 1, 0);
        expect_out("R9 kick in warning", 1, 0, 0);
        wait_n(T - 1);
        chk("R9 fresh interval early", int'(state_o), 1);
        wait_n(1);
        expect_out("R9 fresh interval expiry", 2, 1, 0);
    endtask

    // Continues from warning with irq set.
    task automatic t_disable();
        strobe(0, 1, 1, 0);
        expect_out("R10 stop beats kick", 0, 0, 0);
        bus_reset();
        strobe(1, 0, 0, 0);
        wait_n(T);
        chk("R6 warning reached", int'(irq), 1);
        strobe(0, 1, 0, 0);
        expect_out("R6 stop keeps irq", 0, 1, 0);
        wait_n(2 * T);
        expect_out("R10 stopped stays idle", 0, 1, 0);
        strobe(0, 0, 0, 1);
        strobe(1, 0, 0, 0);
        wait_n(T - 1);
        expect_out("R10 restart fresh", 1, 0, 0);
        wait_n(1);
        expect_out("R10 restart expiry", 2, 1, 0);
    endtask

    task automatic t_reenable();
        bus_reset();
        strobe(1, 0, 0, 0);
        wait_n(3);
        strobe(1, 0, 0, 0);
        wait_n(T - 5);
        expect_out("R11 en ignored", 1, 0, 0);
        wait_n(1);
        expect_out("R11 original expiry", 2, 1, 0);
    endtask

    task automatic t_set_vs_ack();
        bus_reset();
        strobe(1, 0, 0, 0);
        wait_n(T - 1);
        strobe(0, 0, 0, 1);
        expect_out("R6 set beats ack", 2, 1, 0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_two_stage();
        t_kick();
        t_disable();
        t_reenable();
        t_set_vs_ack();
        report();
        $finish;
    end

endmodule